// File: doc/BRIEF.md
# Serial Memory Command and Status Controller

This block holds the command decoder and the 8-bit status register of a serial-bus memory slave. Instructions arrive most-significant bit first on `si` while `cs_n` is low. The bus runs in mode 0: `si` is sampled on each rising `sck` edge, and the returned data changes on each falling edge. The block recognises four commands. Read-status shifts the status byte out. Write-status loads the nonvolatile protection bits. Write-enable sets the enable latch and write-disable clears it. Any other opcode makes the block ignore the rest of the selection.

An accepted status write starts an internal busy period that stands in for a nonvolatile programming cycle. The status byte can be polled while this period runs. The bits `cs_n`, `sck` and `si` are sampled by the system clock `clk`. Each `sck` phase must therefore last at least two `clk` cycles. The data output `so` is valid only while `so_en` is high. `so_en` is meant to drive the enable of a pad buffer, which gives a high-impedance line when `so_en` is low.

Top module: `spi_status_ctrl`

## Requirements
- R1: Status byte layout: bit 0 is write-in-progress (WIP), bit 1 is the enable latch (WEL), bits 3:2 are the block-protect pair, bit 7 is the protect-enable bit, and bits 6:4 always read 0.
- R2: After opcode 0x05, the falling edge that follows the eighth rising `sck` edge presents status bit 7 on `so`, and each later falling edge presents the next lower bit. `so_en` is low throughout the instruction byte and whenever `cs_n` is high.
- R3: While `sck` keeps running after bit 0 of a status read, the byte repeats from bit 7. Each bit carries the current value of the register.
- R4: Opcode 0x06 sets WEL and opcode 0x04 clears it. Both work at any time, including while WIP is 1.
- R5: Opcode 0x01 followed by a data byte, when WEL is 1 and WIP is 0, loads data bits 7, 3 and 2 into status bits 7, 3 and 2. Data bits 6:4, 1 and 0 are ignored.
- R6: A status write issued while WEL is 0 or WIP is 1 changes nothing.
- R7: An accepted status write holds WIP at 1 for BUSY_CYCLES `clk` cycles. WEL stays 1 during that time. When the period ends, WIP and WEL both return to 0.
- R8: The protection bits (7, 3, 2) keep their value until the next accepted status write. Enable and disable commands do not change them.
- R9: An unknown opcode, and any byte sent after a complete command, is ignored until `cs_n` rises.
- R10: Raising `cs_n` before a command byte is complete discards that command.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock used to sample the serial pins |
| rst_n | input | 1 | Asynchronous active-low reset |
| cs_n | input | 1 | Active-low chip select |
| sck | input | 1 | Serial clock, mode 0 |
| si | input | 1 | Serial data in, MSB first |
| so | output | 1 | Serial data out, valid while `so_en` is high |
| so_en | output | 1 | Output drive enable; low means the line floats |

## Verification
The bench builds the block with BUSY_CYCLES = 100 and an `sck` half-period of two `clk` cycles. With these values the busy window covers one complete status read issued right after a status write. The same window ends inside a five-byte continuous read, so the WIP and WEL bits can be watched changing in the middle of a single read. At this size, all 256 status-write data values can be swept, each checked once during the busy period and once after it.

// File: rtl/spi_sr_pkg.sv
package spi_sr_pkg;
  localparam int unsigned STAT_W = 8;

  localparam logic [STAT_W-1:0] OPC_READ_STAT  = 8'h05;
  localparam logic [STAT_W-1:0] OPC_WRITE_STAT = 8'h01;
  localparam logic [STAT_W-1:0] OPC_LATCH_SET  = 8'h06;
  localparam logic [STAT_W-1:0] OPC_LATCH_CLR  = 8'h04;

  // bits that a status write may load: protect enable and block protect pair
  localparam logic [STAT_W-1:0] NV_MASK = 8'b1000_1100;
  localparam int unsigned BIT_BUSY  = 0;
  localparam int unsigned BIT_LATCH = 1;

  typedef enum logic [1:0] {
    PH_OPCODE,
    PH_READOUT,
    PH_WDATA,
    PH_IGNORE
  } phase_e;
endpackage

// File: rtl/spi_sr_shifter.sv
module spi_sr_shifter
  import spi_sr_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cs_n,
  input  logic              sck,
  input  logic              si,
  output logic              sck_fall,
  output logic              in_readout,
  output logic              set_p,
  output logic              clr_p,
  output logic              wr_p,
  output logic [STAT_W-1:0] wr_byte
);
  localparam int unsigned CW = $clog2(STAT_W);

  logic              sck_q;
  logic [STAT_W-2:0] sh_q, sh_d;
  logic [CW-1:0]     cnt_q, cnt_d;
  phase_e            ph_q, ph_d;
  logic              sck_rise;
  logic              byte_end;
  logic [STAT_W-1:0] byte_in;

  assign sck_rise = ~cs_n & sck & ~sck_q;
  assign sck_fall = ~cs_n & ~sck & sck_q;
  assign byte_in  = {sh_q, si};
  assign byte_end = sck_rise && (cnt_q == CW'(STAT_W-1));
  assign wr_byte  = byte_in;
  assign in_readout = (ph_q == PH_READOUT);

  always_comb begin
    sh_d  = sh_q;
    cnt_d = cnt_q;
    ph_d  = ph_q;
    set_p = 1'b0;
    clr_p = 1'b0;
    wr_p  = 1'b0;
    if (cs_n) begin
      cnt_d = '0;
      ph_d  = PH_OPCODE;
    end else if (sck_rise) begin
      sh_d  = byte_in[STAT_W-2:0];
      cnt_d = cnt_q + 1'b1;
      if (byte_end) begin
        unique case (ph_q)
          PH_OPCODE: begin
            if (byte_in == OPC_READ_STAT)       ph_d = PH_READOUT;
            else if (byte_in == OPC_WRITE_STAT) ph_d = PH_WDATA;
            else begin
              set_p = (byte_in == OPC_LATCH_SET);
              clr_p = (byte_in == OPC_LATCH_CLR);
              ph_d  = PH_IGNORE;
            end
          end
          PH_WDATA: begin
            wr_p = 1'b1;
            ph_d = PH_IGNORE;
          end
          default: ph_d = ph_q;
        endcase
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sck_q <= 1'b0;
      sh_q  <= '0;
      cnt_q <= '0;
      ph_q  <= PH_OPCODE;
    end else begin
      sck_q <= sck;
      sh_q  <= sh_d;
      cnt_q <= cnt_d;
      ph_q  <= ph_d;
    end
  end

  assert_one_cmd_R9: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({set_p, clr_p, wr_p}));
  assert_abort_R10: assert property (@(posedge clk) disable iff (!rst_n)
    cs_n |=> (ph_q == PH_OPCODE) && (cnt_q == '0));
endmodule

// File: rtl/spi_sr_status.sv
module spi_sr_status
  import spi_sr_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 5000
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              set_p,
  input  logic              clr_p,
  input  logic              wr_p,
  input  logic [STAT_W-1:0] wr_byte,
  output logic [STAT_W-1:0] status
);
  localparam int unsigned TW = $clog2(BUSY_CYCLES + 1);

  logic [STAT_W-1:0] nv_q, nv_d;
  logic              wel_q, wel_d;
  logic [TW-1:0]     tmr_q, tmr_d;
  logic              wip;
  logic              wr_go;
  logic              busy_end;

  assign wip      = (tmr_q != '0);
  assign wr_go    = wr_p & wel_q & ~wip;
  assign busy_end = (tmr_q == TW'(1));

  always_comb begin
    nv_d  = nv_q;
    wel_d = wel_q;
    tmr_d = tmr_q;
    if (wr_go) begin
      nv_d  = wr_byte & NV_MASK;
      tmr_d = TW'(BUSY_CYCLES);
    end else if (wip) begin
      tmr_d = tmr_q - 1'b1;
    end
    if (busy_end)   wel_d = 1'b0;
    else if (set_p) wel_d = 1'b1;
    else if (clr_p) wel_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      nv_q  <= '0;
      wel_q <= 1'b0;
      tmr_q <= '0;
    end else begin
      nv_q  <= nv_d;
      wel_q <= wel_d;
      tmr_q <= tmr_d;
    end
  end

  always_comb begin
    status            = nv_q;
    status[BIT_BUSY]  = wip;
    status[BIT_LATCH] = wel_q;
  end

  assert_latch_src_R4: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wel_q) |-> $past(set_p));
  assert_start_guard_R6: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(wip) |-> $past(wel_q));
  assert_busy_start_R7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_go |=> wip);
  assert_latch_end_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(wip) |-> !wel_q);
  assert_prot_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_go |=> $stable(nv_q));
endmodule

// File: rtl/spi_status_ctrl.sv
module spi_status_ctrl
  import spi_sr_pkg::*;
#(
  parameter int unsigned BUSY_CYCLES = 5000
) (
  input  logic clk,
  input  logic rst_n,
  input  logic cs_n,
  input  logic sck,
  input  logic si,
  output logic so,
  output logic so_en
);
  localparam int unsigned IW = $clog2(STAT_W);

  logic              rst_meta_q, rst_s_q;
  logic              sck_fall, in_readout;
  logic              set_p, clr_p, wr_p;
  logic [STAT_W-1:0] wr_byte, status;
  logic [IW-1:0]     idx_q, idx_d;
  logic              so_q, so_d, en_q, en_d;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_meta_q <= 1'b0;
      rst_s_q    <= 1'b0;
    end else begin
      rst_meta_q <= 1'b1;
      rst_s_q    <= rst_meta_q;
    end
  end

  spi_sr_shifter i_shift (
    .clk        (clk),
    .rst_n      (rst_s_q),
    .cs_n       (cs_n),
    .sck        (sck),
    .si         (si),
    .sck_fall   (sck_fall),
    .in_readout (in_readout),
    .set_p      (set_p),
    .clr_p      (clr_p),
    .wr_p       (wr_p),
    .wr_byte    (wr_byte)
  );

  spi_sr_status #(.BUSY_CYCLES(BUSY_CYCLES)) i_stat (
    .clk     (clk),
    .rst_n   (rst_s_q),
    .set_p   (set_p),
    .clr_p   (clr_p),
    .wr_p    (wr_p),
    .wr_byte (wr_byte),
    .status  (status)
  );

  always_comb begin
    idx_d = idx_q;
    so_d  = so_q;
    en_d  = en_q;
    if (cs_n) begin
      idx_d = IW'(STAT_W-1);
      en_d  = 1'b0;
      so_d  = 1'b0;
    end else if (in_readout && sck_fall) begin
      so_d  = status[idx_q];
      idx_d = idx_q - 1'b1;
      en_d  = 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_s_q) begin
    if (!rst_s_q) begin
      idx_q <= IW'(STAT_W-1);
      so_q  <= 1'b0;
      en_q  <= 1'b0;
    end else begin
      idx_q <= idx_d;
      so_q  <= so_d;
      en_q  <= en_d;
    end
  end

  assign so    = so_q;
  assign so_en = en_q;

  assert_float_deselect_R2: assert property (@(posedge clk) disable iff (!rst_s_q)
    cs_n |=> !so_en);
  assert_drive_only_read_R2: assert property (@(posedge clk) disable iff (!rst_s_q)
    so_en |-> in_readout);
  assert_unused_zero_R1: assert property (@(posedge clk) disable iff (!rst_s_q)
    status[6:4] == 3'b000);
endmodule

// File: tb/test_spi_status_ctrl.sv
module test_spi_status_ctrl;
  localparam int BUSY = 100;
  localparam int HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cs_n = 1'b1;
  logic sck = 1'b0;
  logic si = 1'b0;
  logic so, so_en;
  int checks = 0;
  int errors = 0;
  logic drv_seen;

  always #4 clk = ~clk;

  spi_status_ctrl #(.BUSY_CYCLES(BUSY)) i_spi_status_ctrl (
    .clk(clk), .rst_n(rst_n), .cs_n(cs_n), .sck(sck), .si(si),
    .so(so), .so_en(so_en)
  );

  task automatic chk(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual %02h expected %02h", req, act, exp);
    end
  endtask

  task automatic sel();
    @(negedge clk); cs_n = 1'b0;
    repeat (2) @(negedge clk);
  endtask

  task automatic desel();
    repeat (2) @(negedge clk);
    cs_n = 1'b1;
    repeat (3) @(negedge clk);
  endtask

  task automatic xbyte(input logic [7:0] d, input int nbits, output logic [7:0] q, output logic en_any);
    q = '0; en_any = 1'b0;
    for (int i = 7; i > 7 - nbits; i--) begin
      si = d[i];
      repeat (HALF) @(negedge clk);
      q[i] = so;
      en_any = en_any | so_en;
      sck = 1'b1;
      repeat (HALF) @(negedge clk);
      sck = 1'b0;
    end
  endtask

  task automatic cmd1(input logic [7:0] op);
    logic [7:0] q; logic e;
    sel(); xbyte(op, 8, q, e); desel();
  endtask

  task automatic cmd2(input logic [7:0] op, input logic [7:0] d);
    logic [7:0] q; logic e;
    sel(); xbyte(op, 8, q, e); xbyte(d, 8, q, e); desel();
  endtask

  task automatic rdsr(output logic [7:0] v);
    logic [7:0] q; logic e;
    sel();
    xbyte(8'h05, 8, q, e);
    drv_seen = e;
    xbyte(8'h00, 8, v, e);
    desel();
  endtask

  task automatic wait_idle(output logic [7:0] v);
    for (int n = 0; n < 20; n++) begin
      rdsr(v);
      if (v[0] == 1'b0) break;
    end
  endtask

  initial begin
    repeat (150000) @(negedge clk);
    errors++;
    $display("FAIL watchdog actual %0d expected %0d", 1, 0);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    logic [7:0] v, q, exp;
    logic e;
    logic [7:0] rb [5];
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    chk("R2 reset so_en", {7'b0, so_en}, 8'h00);
    rdsr(v);
    chk("R1 reset status", v, 8'h00);
    chk("R2 no drive during opcode", {7'b0, drv_seen}, 8'h00);
    chk("R2 float after deselect", {7'b0, so_en}, 8'h00);

    cmd2(8'h01, 8'h8C);
    rdsr(v);
    chk("R6 write with latch clear", v, 8'h00);

    cmd1(8'h06); rdsr(v);
    chk("R4 enable sets latch", v, 8'h02);
    cmd1(8'h04); rdsr(v);
    chk("R4 disable clears latch", v, 8'h00);

    sel(); xbyte(8'h06, 7, q, e); desel();
    rdsr(v);
    chk("R10 partial opcode dropped", v, 8'h00);

    sel(); xbyte(8'hFF, 8, q, e); xbyte(8'h05, 8, q, e); xbyte(8'h00, 8, q, e); desel();
    chk("R9 unknown opcode no drive", {7'b0, e}, 8'h00);
    rdsr(v);
    chk("R9 unknown opcode no change", v, 8'h00);
    sel(); xbyte(8'h06, 8, q, e); xbyte(8'h04, 8, q, e); desel();
    rdsr(v);
    chk("R9 trailing byte ignored", v, 8'h02);

    sel(); xbyte(8'h05, 8, q, e);
    for (int k = 0; k < 3; k++) begin
      xbyte(8'h00, 8, q, e);
      chk("R3 repeated byte", q, 8'h02);
    end
    desel();

    cmd2(8'h01, 8'h84);
    sel(); xbyte(8'h05, 8, q, e);
    for (int k = 0; k < 5; k++) begin
      xbyte(8'h00, 8, rb[k], e);
    end
    desel();
    chk("R3 live value while busy", rb[0], 8'h87);
    chk("R3 live value after busy", rb[4], 8'h84);

    cmd1(8'h06);
    cmd2(8'h01, 8'h0C);
    cmd2(8'h01, 8'h80);
    wait_idle(v);
    chk("R6 write during busy ignored", v, 8'h0C);
    cmd1(8'h06); rdsr(v);
    chk("R8 enable keeps protection", v, 8'h0E);
    cmd1(8'h04); rdsr(v);
    chk("R8 disable keeps protection", v, 8'h0C);

    for (int d = 0; d < 256; d++) begin
      exp = 8'(d) & 8'h8C;
      cmd1(8'h06);
      cmd2(8'h01, 8'(d));
      rdsr(v);
      chk("R7 busy and latch during write", v, exp | 8'h03);
      wait_idle(v);
      chk("R5 loaded bits after write", v, exp);
    end

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule